// File: doc/BRIEF.md
# Memory-Mapped I/O Page with Serial Port

This block sits between a small CPU and its main memory. The CPU has a 12-bit address space of 16-bit words. The block claims the sixteen addresses whose upper eight bits are all ones and passes every other access to the memory bus unchanged. Four of the claimed addresses are in use:

- 0xFF0 holds a general-purpose switch register that software can both read and write.
- 0xFF1 reports the physical slide switches and the enter key.
- 0xFFE is a serial-port status word.
- 0xFFF is the serial-port data word.

The serial port runs a fixed 8-data-bit, no-parity, one-stop-bit frame at a baud rate set by parameter. The default is 57600 baud from a 40 MHz clock.

A load input switches the receiver into a program-loading role. In that role, received bytes no longer reach the data word. Each pair of bytes is joined into one 16-bit word, high byte first, and that word is presented with a one-cycle strobe so that surrounding logic can deposit it into memory.

Top module: `mmio_serial_page`

## Requirements
- R1: A write to offset 0x0 of the page stores all 16 data bits in the switch register, and a read of 0x0 returns them. The register is 0 after reset, and no other access changes it.
- R2: A read of offset 0x1 returns the enter key in bit 15, zeros in bits 14..8 and the eight switches in bits 7..0. Writes to 0x1 have no effect.
- R3: A read of offset 0xE returns the status word:
  - bit 0: a received byte is waiting
  - bit 1: overrun
  - bit 2: framing error
  - bit 3: transmit shifter idle
  - bit 4: transmit holding register free
  - bits 15..5: zero
- R4: A read of offset 0xF returns the waiting flag in bit 15, zeros in bits 14..8 and the last received byte in bits 7..0. The read clears the waiting flag.
- R5: A write to offset 0xF sends data bits 7..0 as one frame, least significant bit first, each bit lasting CLK_HZ/(16·BAUD)·16 clocks. The frame is a low start bit, eight data bits and a high stop bit. A write made while the holding register is occupied is discarded.
- R6: The holding-free flag drops for the cycles the written byte waits in the holding register. The shifter-idle flag is low for the whole frame. Both flags are high again once the line returns to idle.
- R7: The receiver samples at sixteen times the bit rate and takes each bit near its middle. A low pulse on the line shorter than half a bit is ignored.
- R8: A byte that completes while the waiting flag is still set replaces the old byte and sets overrun. Overrun stays set until the status word is read.
- R9: A byte whose stop bit samples low sets the framing-error flag and is still delivered. The flag stays set until the status word is read.
- R10: Accesses outside the page drive the memory strobes from the CPU strobes and return the memory read data. Accesses inside the page keep both memory strobes low. Unused page offsets read zero.
- R11: While load mode is on, received bytes leave the waiting flag and the data word untouched. Every two bytes produce one word on the load outputs, with the first byte in bits 15..8, and a single-cycle strobe.
- R12: Turning load mode off discards a half-assembled word, so the next byte after load mode resumes is taken as a high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| load_mode | input | 1 | Routes received bytes to the word assembler |
| switches | input | 8 | Physical slide switches |
| enter_key | input | 1 | Enter push-button level |
| rxd | input | 1 | Serial receive line, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe (one cycle per read) |
| cpu_rdata | output | 16 | Read data returned to the CPU |
| mem_addr | output | AW | Address to main memory |
| mem_wdata | output | 16 | Write data to main memory |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 16 | Read data from main memory |
| load_word | output | 16 | Assembled word in load mode |
| load_strobe | output | 1 | One-cycle pulse when load_word is new |

## Verification
The assertions check the following rules on every cycle:
- the switch register holds its value unless it is written;
- memory strobes stay low inside the page;
- a data read clears the waiting flag;
- overrun and framing errors latch, and overrun stays set until a status read;
- received pulses and load strobes last one cycle;
- every transmitted frame opens with a low start bit;
- load mode never raises the waiting flag.

Only the bench scenarios can show the following:
- that frames decode to the right byte at the right bit timing in both directions;
- that a short glitch is rejected;
- that a write into a full holding register never reaches the line;
- that bytes pair high-then-low, and re-pair correctly after load mode is toggled.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int OVS    = 16;
    localparam int FRAME_BITS = BYTE_W + 2;

    // page offsets
    localparam logic [3:0] OFS_SWREG = 4'h0;
    localparam logic [3:0] OFS_SWIN  = 4'h1;
    localparam logic [3:0] OFS_STAT  = 4'hE;
    localparam logic [3:0] OFS_DATA  = 4'hF;

    // status word bit positions
    localparam int ST_AVAIL      = 0;
    localparam int ST_OVERRUN    = 1;
    localparam int ST_FRAMING    = 2;
    localparam int ST_SHIFT_IDLE = 3;
    localparam int ST_HOLD_FREE  = 4;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_phase_e;

    typedef struct packed {
        logic [1:0]        sync;
        rx_phase_e         phase;
        logic [3:0]        tick_cnt;
        logic [2:0]        bit_idx;
        logic [BYTE_W-1:0] shift;
        logic              done;
        logic              ferr;
    } rx_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0]     hold;
        logic                  hold_full;
        logic [FRAME_BITS-1:0] shreg;
        logic [3:0]            tick_cnt;
        logic [3:0]            bits_left;
        logic                  busy;
    } tx_state_t;

    typedef struct packed {
        logic              phase;
        logic [BYTE_W-1:0] high;
        logic [WORD_W-1:0] word;
        logic              strobe;
    } ld_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] swreg;
        logic [BYTE_W-1:0] rx_byte;
        logic              avail;
        logic              overrun;
        logic              framing;
    } page_state_t;

endpackage

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int CLK_HZ = 40_000_000,
    parameter int BAUD   = 57_600
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    import mmio_pkg::*;

    localparam int RAW_DIV = CLK_HZ / (BAUD * OVS);
    localparam int DIV     = (RAW_DIV < 1) ? 1 : RAW_DIV;
    localparam int CW      = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          tick_d, tick_q;

    always_comb begin
        if (cnt_q == CW'(DIV - 1)) begin
            cnt_d  = '0;
            tick_d = 1'b1;
        end else begin
            cnt_d  = cnt_q + 1'b1;
            tick_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    assign tick = tick_q;

    generate
        if (DIV > 1) begin : g_spacing
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick_q |=> !tick_q); // R7
        end
    endgenerate

endmodule

// File: rtl/serial_rx.sv
module serial_rx (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       rxd,
    output logic                       done,
    output logic [mmio_pkg::BYTE_W-1:0] data,
    output logic                       ferr
);
    import mmio_pkg::*;

    localparam logic [3:0] HALF = 4'(OVS / 2 - 1);
    localparam logic [3:0] FULL = 4'(OVS - 1);
    localparam logic [2:0] LAST = 3'(BYTE_W - 1);

    rx_state_t s_d, s_q;
    logic      line;

    assign line = s_q.sync[1];

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.sync = {s_q.sync[0], rxd};
        if (tick) begin
            unique case (s_q.phase)
                RX_IDLE: begin
                    if (!line) begin
                        s_d.phase    = RX_START;
                        s_d.tick_cnt = '0;
                    end
                end
                RX_START: begin
                    if (s_q.tick_cnt == HALF) begin
                        if (!line) begin
                            s_d.phase    = RX_DATA;
                            s_d.tick_cnt = '0;
                            s_d.bit_idx  = '0;
                        end else begin
                            s_d.phase = RX_IDLE;
                        end
                    end else begin
                        s_d.tick_cnt = s_q.tick_cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (s_q.tick_cnt == FULL) begin
                        s_d.tick_cnt = '0;
                        s_d.shift    = {line, s_q.shift[BYTE_W-1:1]};
                        if (s_q.bit_idx == LAST) s_d.phase = RX_STOP;
                        else                     s_d.bit_idx = s_q.bit_idx + 1'b1;
                    end else begin
                        s_d.tick_cnt = s_q.tick_cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (s_q.tick_cnt == FULL) begin
                        s_d.done  = 1'b1;
                        s_d.ferr  = !line;
                        s_d.phase = RX_IDLE;
                    end else begin
                        s_d.tick_cnt = s_q.tick_cnt + 1'b1;
                    end
                end
                default: s_d.phase = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.sync  <= 2'b11;
            s_q.phase <= RX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign done = s_q.done;
    assign data = s_q.shift;
    assign ferr = s_q.ferr;

    AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

endmodule

// File: rtl/serial_tx.sv
module serial_tx (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        wr_en,
    input  logic [mmio_pkg::BYTE_W-1:0] wr_data,
    output logic                        txd,
    output logic                        hold_free,
    output logic                        shift_idle
);
    import mmio_pkg::*;

    localparam logic [3:0] FULL = 4'(OVS - 1);

    tx_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.busy && s_q.hold_full) begin
            s_d.shreg     = {1'b1, s_q.hold, 1'b0};
            s_d.busy      = 1'b1;
            s_d.bits_left = 4'(FRAME_BITS);
            s_d.tick_cnt  = '0;
            s_d.hold_full = 1'b0;
        end else if (s_q.busy && tick) begin
            if (s_q.tick_cnt == FULL) begin
                s_d.tick_cnt  = '0;
                s_d.shreg     = {1'b1, s_q.shreg[FRAME_BITS-1:1]};
                s_d.bits_left = s_q.bits_left - 1'b1;
                if (s_q.bits_left == 4'd1) s_d.busy = 1'b0;
            end else begin
                s_d.tick_cnt = s_q.tick_cnt + 1'b1;
            end
        end
        if (wr_en && !s_q.hold_full) begin
            s_d.hold      = wr_data;
            s_d.hold_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.shreg <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd        = s_q.busy ? s_q.shreg[0] : 1'b1;
    assign hold_free  = !s_q.hold_full;
    assign shift_idle = !s_q.busy;

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> !txd); // R5
    AST_TX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.hold_full && s_q.busy && wr_en) |=> (s_q.hold == $past(s_q.hold))); // R5

endmodule

// File: rtl/word_pair_loader.sv
module word_pair_loader (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic                        byte_valid,
    input  logic [mmio_pkg::BYTE_W-1:0] byte_data,
    output logic [mmio_pkg::WORD_W-1:0] word,
    output logic                        strobe
);
    import mmio_pkg::*;

    ld_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        if (!enable) begin
            s_d.phase = 1'b0;
        end else if (byte_valid) begin
            if (!s_q.phase) begin
                s_d.high  = byte_data;
                s_d.phase = 1'b1;
            end else begin
                s_d.word   = {s_q.high, byte_data};
                s_d.strobe = 1'b1;
                s_d.phase  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word   = s_q.word;
    assign strobe = s_q.strobe;

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe); // R11
    AST_LOAD_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !s_q.phase); // R12

endmodule

// File: rtl/mmio_serial_page.sv
module mmio_serial_page #(
    parameter int CLK_HZ = 40_000_000,
    parameter int BAUD   = 57_600,
    parameter int AW     = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_mode,
    input  logic [7:0]    switches,
    input  logic          enter_key,
    input  logic          rxd,
    output logic          txd,
    input  logic [AW-1:0] cpu_addr,
    input  logic [15:0]   cpu_wdata,
    input  logic          cpu_we,
    input  logic          cpu_re,
    output logic [15:0]   cpu_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    output logic          mem_we,
    output logic          mem_re,
    input  logic [15:0]   mem_rdata,
    output logic [15:0]   load_word,
    output logic          load_strobe
);
    import mmio_pkg::*;

    localparam int TAG_W = AW - 4;

    page_state_t       s_d, s_q;
    logic              tick;
    logic              rx_done, rx_ferr;
    logic [BYTE_W-1:0] rx_data;
    logic              tx_hold_free, tx_shift_idle;
    logic              in_page;
    logic [3:0]        ofs;
    logic              wr_swreg, wr_data, rd_stat, rd_data;
    logic [15:0]       stat_word;

    assign in_page  = (cpu_addr[AW-1:4] == {TAG_W{1'b1}});
    assign ofs      = cpu_addr[3:0];
    assign wr_swreg = cpu_we && in_page && (ofs == OFS_SWREG);
    assign wr_data  = cpu_we && in_page && (ofs == OFS_DATA);
    assign rd_stat  = cpu_re && in_page && (ofs == OFS_STAT);
    assign rd_data  = cpu_re && in_page && (ofs == OFS_DATA);

    baud_tick_gen #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    serial_rx i_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .rxd  (rxd),
        .done (rx_done),
        .data (rx_data),
        .ferr (rx_ferr)
    );

    serial_tx i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_data),
        .wr_data   (cpu_wdata[BYTE_W-1:0]),
        .txd       (txd),
        .hold_free (tx_hold_free),
        .shift_idle(tx_shift_idle)
    );

    word_pair_loader i_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (load_mode),
        .byte_valid(rx_done),
        .byte_data (rx_data),
        .word      (load_word),
        .strobe    (load_strobe)
    );

    // next-state
    always_comb begin
        s_d = s_q;
        if (wr_swreg) s_d.swreg = cpu_wdata;
        if (rd_stat) begin
            s_d.overrun = 1'b0;
            s_d.framing = 1'b0;
        end
        if (rd_data) s_d.avail = 1'b0;
        if (rx_done) begin
            if (rx_ferr) s_d.framing = 1'b1;
            if (!load_mode) begin
                if (s_q.avail && !rd_data) s_d.overrun = 1'b1;
                s_d.rx_byte = rx_data;
                s_d.avail   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // read mux
    always_comb begin
        stat_word                = '0;
        stat_word[ST_AVAIL]      = s_q.avail;
        stat_word[ST_OVERRUN]    = s_q.overrun;
        stat_word[ST_FRAMING]    = s_q.framing;
        stat_word[ST_SHIFT_IDLE] = tx_shift_idle;
        stat_word[ST_HOLD_FREE]  = tx_hold_free;
        if (!in_page) begin
            cpu_rdata = mem_rdata;
        end else begin
            unique case (ofs)
                OFS_SWREG: cpu_rdata = s_q.swreg;
                OFS_SWIN:  cpu_rdata = {enter_key, 7'b0, switches};
                OFS_STAT:  cpu_rdata = stat_word;
                OFS_DATA:  cpu_rdata = {s_q.avail, 7'b0, s_q.rx_byte};
                default:   cpu_rdata = '0;
            endcase
        end
    end

    assign mem_addr  = cpu_addr;
    assign mem_wdata = cpu_wdata;
    assign mem_we    = cpu_we && !in_page;
    assign mem_re    = cpu_re && !in_page;

    AST_SWREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_swreg |=> $stable(s_q.swreg)); // R1
    AST_PAGE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[AW-1:4] == {TAG_W{1'b1}}) |-> (!mem_we && !mem_re)); // R10
    AST_READ_CLEARS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_done) |=> !s_q.avail); // R4
    AST_NO_OVERFLOW_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !load_mode && s_q.avail && !rd_data) |=> s_q.overrun); // R8
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.overrun && !rd_stat) |=> s_q.overrun); // R8
    AST_FRAMING_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_ferr) |=> s_q.framing); // R9
    AST_LOAD_NO_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (load_mode && !s_q.avail) |=> !s_q.avail); // R11

endmodule

// File: tb/test_mmio_serial_page.sv
module test_mmio_serial_page;

    localparam int CLK_HZ_TB = 6_400_000;
    localparam int BAUD_TB   = 100_000;
    localparam int BIT_CLKS  = 64;   // 16 ticks x divider 4
    localparam int AW        = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_mode = 1'b0;
    logic [7:0]    switches = 8'h00;
    logic          enter_key = 1'b0;
    logic          rxd = 1'b1;
    logic          txd;
    logic [AW-1:0] cpu_addr = '0;
    logic [15:0]   cpu_wdata = '0;
    logic          cpu_we = 1'b0;
    logic          cpu_re = 1'b0;
    logic [15:0]   cpu_rdata;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic          mem_we, mem_re;
    logic [15:0]   mem_rdata = 16'h0000;
    logic [15:0]   load_word;
    logic          load_strobe;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;
    int ld_count = 0;
    logic [15:0] ld_last = '0;

    always #10 clk = ~clk;

    mmio_serial_page #(.CLK_HZ(CLK_HZ_TB), .BAUD(BAUD_TB), .AW(AW)) i_mmio_serial_page (
        .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .switches(switches),
        .enter_key(enter_key), .rxd(rxd), .txd(txd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .load_word(load_word), .load_strobe(load_strobe)
    );

    always @(negedge clk) begin
        if (load_strobe) begin
            ld_count = ld_count + 1;
            ld_last  = load_word;
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // callers are positioned at a negedge
    task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [15:0] d);
        cpu_addr = a; cpu_re = 1'b1;
        #2 d = cpu_rdata;
        @(negedge clk);
        cpu_re = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic stop);
        rxd = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rxd = stop;
        repeat (BIT_CLKS) @(negedge clk);
        rxd = 1'b1;
        repeat (16) @(negedge clk);
    endtask

    task automatic recv_frame(output logic [7:0] b, output bit ok);
        bit seen = 1'b0;
        logic st, sp;
        b = '0;
        for (int i = 0; i < 4 * BIT_CLKS * 10; i++) begin
            if (txd === 1'b0) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        repeat (BIT_CLKS / 2) @(negedge clk);
        st = txd;
        for (int i = 0; i < 8; i++) begin
            repeat (BIT_CLKS) @(negedge clk);
            b[i] = txd;
        end
        repeat (BIT_CLKS) @(negedge clk);
        sp = txd;
        ok = seen && (st === 1'b0) && (sp === 1'b1);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        bus_read(12'hFF0, d); check("R1 reset switch register", d, 16'h0000);
        bus_read(12'hFFE, d); check("R3 reset status", d, 16'h0018);
        bus_read(12'hFFF, d); check("R4 reset data word", d, 16'h0000);
        check("R5 idle line high", {15'b0, txd}, 16'h0001);
    endtask

    task automatic t_switch_regs;
        logic [15:0] d;
        bus_write(12'hFF0, 16'hA5C3);
        bus_read(12'hFF0, d); check("R1 switch register readback", d, 16'hA5C3);
        switches = 8'h3C; enter_key = 1'b1;
        bus_read(12'hFF1, d); check("R2 switches and enter", d, 16'h803C);
        bus_write(12'hFF1, 16'hFFFF);
        bus_read(12'hFF1, d); check("R2 write to switch port ignored", d, 16'h803C);
        bus_read(12'hFF0, d); check("R1 register unchanged by other write", d, 16'hA5C3);
        enter_key = 1'b0;
        bus_read(12'hFF1, d); check("R2 enter released", d, 16'h003C);
    endtask

    task automatic t_passthrough;
        logic [15:0] d;
        cpu_addr = 12'h123; cpu_wdata = 16'hBEEF; cpu_we = 1'b1;
        #2 check("R10 outside write strobe", {15'b0, mem_we}, 16'h0001);
        check("R10 outside address", {4'b0, mem_addr}, 16'h0123);
        check("R10 outside write data", mem_wdata, 16'hBEEF);
        @(negedge clk); cpu_we = 1'b0;
        cpu_addr = 12'hFF0; cpu_wdata = 16'h1111; cpu_we = 1'b1;
        #2 check("R10 inside write blocked", {15'b0, mem_we}, 16'h0000);
        @(negedge clk); cpu_we = 1'b0;
        mem_rdata = 16'h4321;
        bus_read(12'h7FF, d); check("R10 outside read data", d, 16'h4321);
        cpu_addr = 12'hFF5; cpu_re = 1'b1;
        #2 check("R10 inside read blocked", {15'b0, mem_re}, 16'h0000);
        check("R10 unused offset reads zero", cpu_rdata, 16'h0000);
        @(negedge clk); cpu_re = 1'b0;
    endtask

    task automatic t_rx_basic;
        logic [15:0] d;
        send_byte(8'hA7, 1'b1);
        bus_read(12'hFFE, d); check("R3 R7 status after byte", d, 16'h0019);
        bus_read(12'hFFF, d); check("R4 R7 data with flag", d, 16'h80A7);
        bus_read(12'hFFF, d); check("R4 flag cleared by read", d, 16'h00A7);
    endtask

    task automatic t_glitch;
        logic [15:0] d;
        rxd = 1'b0;
        repeat (20) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT_CLKS * 12) @(negedge clk);
        bus_read(12'hFFE, d); check("R7 short pulse ignored", d, 16'h0018);
    endtask

    task automatic t_overrun;
        logic [15:0] d;
        send_byte(8'h11, 1'b1);
        send_byte(8'h22, 1'b1);
        bus_read(12'hFFE, d); check("R8 overrun set", d, 16'h001B);
        bus_read(12'hFFE, d); check("R8 overrun cleared by status read", d, 16'h0019);
        bus_read(12'hFFF, d); check("R8 newer byte kept", d, 16'h8022);
    endtask

    task automatic t_framing;
        logic [15:0] d;
        send_byte(8'h5A, 1'b0);
        bus_read(12'hFFE, d); check("R9 framing error set", d, 16'h001D);
        bus_read(12'hFFF, d); check("R9 byte still delivered", d, 16'h805A);
        bus_read(12'hFFE, d); check("R9 framing cleared by status read", d, 16'h0018);
    endtask

    task automatic t_tx;
        logic [15:0] d;
        logic [7:0] b;
        bit ok;
        bus_write(12'hFFF, 16'h0096);
        bus_read(12'hFFE, d); check("R6 holding occupied", d, 16'h0008);
        bus_read(12'hFFE, d); check("R6 shifter busy", d, 16'h0010);
        recv_frame(b, ok);
        check("R5 frame shape", {15'b0, ok}, 16'h0001);
        check("R5 frame byte", {8'b0, b}, 16'h0096);
        repeat (BIT_CLKS) @(negedge clk);
        bus_read(12'hFFE, d); check("R6 idle after frame", d, 16'h0018);
    endtask

    task automatic t_tx_drop;
        logic [7:0] b;
        bit ok;
        bit low_seen = 1'b0;
        bus_write(12'hFFF, 16'h003C);
        @(negedge clk);
        bus_write(12'hFFF, 16'h00C3);
        bus_write(12'hFFF, 16'h0055);
        recv_frame(b, ok);
        check("R5 first frame", {7'b0, ok, b}, 16'h013C);
        recv_frame(b, ok);
        check("R5 buffered frame", {7'b0, ok, b}, 16'h01C3);
        for (int i = 0; i < BIT_CLKS * 12; i++) begin
            if (txd !== 1'b1) low_seen = 1'b1;
            @(negedge clk);
        end
        check("R5 write into full holding dropped", {15'b0, low_seen}, 16'h0000);
    endtask

    task automatic t_load;
        logic [15:0] d;
        int base;
        base = ld_count;
        load_mode = 1'b1;
        send_byte(8'h12, 1'b1);
        check("R11 no word after one byte", 16'(ld_count - base), 16'h0000);
        send_byte(8'h34, 1'b1);
        check("R11 one word after two bytes", 16'(ld_count - base), 16'h0001);
        check("R11 high byte first", ld_last, 16'h1234);
        bus_read(12'hFFE, d); check("R11 waiting flag untouched", d, 16'h0018);
    endtask

    task automatic t_realign;
        int base;
        base = ld_count;
        load_mode = 1'b1;
        send_byte(8'hAB, 1'b1);
        load_mode = 1'b0;
        repeat (4) @(negedge clk);
        load_mode = 1'b1;
        send_byte(8'h56, 1'b1);
        check("R12 half word discarded", 16'(ld_count - base), 16'h0000);
        send_byte(8'h78, 1'b1);
        check("R12 fresh pair", ld_last, 16'h5678);
        check("R12 single word", 16'(ld_count - base), 16'h0001);
        load_mode = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_switch_regs();
        t_passthrough();
        t_rx_basic();
        t_glitch();
        t_overrun();
        t_framing();
        t_tx();
        t_tx_drop();
        t_load();
        t_realign();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog expired before all scenarios ended");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule